// File: doc/BRIEF.md
# Accumulator Machine Timing and Execute Sequencer

This block is the hardwired control core of a small 16-bit accumulator machine. Its datapath holds the program counter, address register, instruction register, data register, accumulator, carry-extension bit and indirect bit. The block also owns an internal word store of 2^ADDR_W words of WORD_W bits. A 4-bit step counter feeds a 4-to-16 decoder that produces one-hot timing states. The 3-bit operation field of the instruction register feeds a 3-to-8 decoder. Every register transfer is enabled by the AND of one timing line and, from the third step onward, one operation line.

The block fetches each instruction and resolves indirect addressing. It then executes the memory-reference operations AND, ADD, LDA and BSA. The remaining memory-reference codes are accepted and do nothing. Every register-reference and I/O word is also accepted and does nothing. When an instruction finishes, a synchronous clear of the step counter makes the next cycle start again at T0.

A program and its data are written into the word store through a preload port while the core is held in reset. Releasing reset starts execution at address 0. The accumulator, program counter and carry bit are brought out so the effect of each instruction can be observed.

Top module: `acc_seq_core`

## Requirements
- R1: While rst_n is low at a rising edge, PC, AC and E become 0 and the step counter becomes 0. The first rising edge after release performs T0 of the instruction at address 0.
- R2: Each instruction is read from the word at PC. PC advances by exactly one during the fetch, so programs run from consecutive addresses.
- R3: Bit 15 of an instruction word is the indirect flag and bits 14:12 are the operation code. Bits 11:0 are the address. With code 2 (LDA), AC takes the word at the effective address, and the instruction takes 6 cycles.
- R4: With code 0 (AND), AC becomes the bitwise AND of AC and the word at the effective address, in 6 cycles.
- R5: With code 1 (ADD), AC becomes the low 16 bits of AC plus the operand and E takes the carry out, in 6 cycles. A zero result with a carry gives AC=0 and E=1.
- R6: When bit 15 is 1 and the code is not 7, the effective address is the low 12 bits of the word stored at the address field. When bit 15 is 0, the effective address is the address field itself.
- R7: With code 5 (BSA), the already-advanced PC is written, zero-extended, into the effective address. PC then becomes the effective address plus one, in 6 cycles.
- R8: Codes 3, 4 and 6 leave AC, E and memory unchanged and end after 5 cycles, with either value of bit 15.
- R9: Code 7 leaves AC and E unchanged and ends after 4 cycles, with either value of bit 15.
- R10: While ld_en is high at a rising edge, the word ld_data is stored at ld_addr. A write through this port takes priority over a core write.
- R11: Exactly one timing line is active at all times. The step counter either advances by one or returns to 0, so instructions run back to back with no idle cycle.
- R12: AC changes only on the last step of an instruction. E changes only on the last step of an ADD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Preload write strobe for the word store |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word value |
| acc_out | output | 16 | Accumulator contents |
| pc_out | output | 12 | Program counter contents |
| e_out | output | 1 | Carry-extension bit |

## Verification
The checker takes for granted that the preload port is used only while reset is held. A preload during execution would change memory in a way the step-by-step properties do not model. The bench therefore writes every program and data word with rst_n low and releases reset on a falling edge. After that it leaves ld_en low for the whole run and any later reset phase. The properties also assume that reset lasts at least one full clock, and the bench always holds it for several.

// File: rtl/acc_seq_pkg.sv
// Shared widths and derived counts for the accumulator sequencer.
// Assumes a single clock domain; no types depend on tool options.
package acc_seq_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 12;
    localparam int SC_W   = 4;
    localparam int OPC_W  = 3;
    localparam int NSTATE = 1 << SC_W;
    localparam int NOPC   = 1 << OPC_W;
    localparam int PAD_W  = WORD_W - ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/line_decoder.sv
// Binary-to-one-hot decoder: raises exactly the output line whose index
// equals the input code. Assumes 2**IN_W outputs are all wanted.
module line_decoder #(
    parameter int IN_W = 3,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] lines
);
    // One comparator per output line.
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign lines[i] = (code == IN_W'(i));
    end
endmodule

// File: rtl/seq_timer.sv
// Step counter with synchronous clear and one-hot timing outputs.
// Assumes clr is a registered-path control from the same clock domain.
module seq_timer #(
    parameter int SC_W = 4,
    localparam int NSTATE = 1 << SC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    output logic [SC_W-1:0]   sc,
    output logic [NSTATE-1:0] t_line
);
    logic [SC_W-1:0] sc_q;

    // Advance each cycle, or return to step 0 on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sc_q <= '0;
        else               sc_q <= sc_q + SC_W'(1);
    end

    assign sc = sc_q;

    line_decoder #(.IN_W(SC_W)) u_tdec (
        .code  (sc_q),
        .lines (t_line)
    );
endmodule

// File: rtl/word_store.sv
// Single-write, single-asynchronous-read word memory without reset.
// Assumes the caller resolves write-port priority before we/waddr/wdata.
module word_store #(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Store one word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/acc_seq_core.sv
// Hardwired timing and execute sequencer for a 16-bit accumulator machine.
// Fetch: T0 AR<-PC, T1 IR<-M[AR] and PC+1, T2 AR<-addr and I<-bit15.
// T3 resolves indirection for memory-reference codes; code 7 ends at T3.
// AND/ADD/LDA read the operand at T4 and finish at T5; BSA stores PC at T4
// and jumps at T5; codes 3, 4 and 6 end at T4. Assumes preload only in reset.
module acc_seq_core
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    output logic [WORD_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              e_out
);
    addr_t pc_q, ar_q;
    word_t ir_q, dr_q, ac_q;
    logic  e_q, i_q;

    logic [SC_W-1:0]   sc_q;
    logic [NSTATE-1:0] t;
    logic [NOPC-1:0]   d;
    word_t             mem_rd;

    logic  rd_op, idle_mr, mref, stray, sc_clr;
    logic  bsa_wr, mem_we;
    addr_t mem_waddr;
    word_t mem_wdata;

    // Operation groups formed from decoded lines.
    assign mref    = !d[7];
    assign rd_op   = d[0] | d[1] | d[2];
    assign idle_mr = d[3] | d[4] | d[6];
    assign stray   = |t[NSTATE-1:6];
    assign sc_clr  = (t[3] & d[7]) | (t[4] & idle_mr)
                   | (t[5] & (rd_op | d[5])) | stray;

    // Preload owns the write port over the BSA store.
    assign bsa_wr    = t[4] & d[5];
    assign mem_we    = ld_en | bsa_wr;
    assign mem_waddr = ld_en ? ld_addr : ar_q;
    assign mem_wdata = ld_en ? ld_data : {{PAD_W{1'b0}}, pc_q};

    seq_timer #(.SC_W(SC_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (sc_clr),
        .sc     (sc_q),
        .t_line (t)
    );

    line_decoder #(.IN_W(OPC_W)) u_odec (
        .code  (ir_q[WORD_W-2 -: OPC_W]),
        .lines (d)
    );

    word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ar_q),
        .rdata (mem_rd)
    );

    // Register transfers gated by timing line and operation line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ar_q <= '0;
            ir_q <= '0;
            dr_q <= '0;
            ac_q <= '0;
            e_q  <= 1'b0;
            i_q  <= 1'b0;
        end else begin
            if (t[0]) ar_q <= pc_q;
            if (t[1]) begin
                ir_q <= mem_rd;
                pc_q <= pc_q + ADDR_W'(1);
            end
            if (t[2]) begin
                ar_q <= ir_q[ADDR_W-1:0];
                i_q  <= ir_q[WORD_W-1];
            end
            if (t[3] && mref && i_q) ar_q <= mem_rd[ADDR_W-1:0];
            if (t[4] && rd_op)       dr_q <= mem_rd;
            if (t[4] && d[5])        ar_q <= ar_q + ADDR_W'(1);
            if (t[5]) begin
                if (d[0]) ac_q <= ac_q & dr_q;
                if (d[1]) {e_q, ac_q} <= {1'b0, ac_q} + {1'b0, dr_q};
                if (d[2]) ac_q <= dr_q;
                if (d[5]) pc_q <= ar_q;
            end
        end
    end

    assign acc_out = ac_q;
    assign pc_out  = pc_q;
    assign e_out   = e_q;
endmodule

// File: rtl/acc_seq_chk.sv
// Temporal properties of the sequencer, bound into acc_seq_core.
// Assumes the preload port is idle whenever reset is released.
module acc_seq_chk
    import acc_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [SC_W-1:0]   sc,
    input logic [NSTATE-1:0] t,
    input logic [NOPC-1:0]   d,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ac,
    input logic              e
);
    // R11: one timing line at a time
    p_one_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(t) == 1);

    // R11: counter only steps by one or restarts
    p_sc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc != '0) |-> (sc == $past(sc) + SC_W'(1)));

    // R9: code 7 ends after T3
    p_reg_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (t[3] && d[7]) |=> (sc == '0));

    // R8: idle memory-reference codes end after T4
    p_idle_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t[4] && (d[3] || d[4] || d[6])) |=> (sc == '0));

    // R3: nothing runs past T5
    p_t5_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        t[5] |=> (sc == '0));

    // R2: PC moves only in fetch or at the BSA jump
    p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(t[1] || t[5]) |=> $stable(pc));

    // R12: AC changes only on the final step
    p_ac_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !t[5] |=> $stable(ac));

    // R12: E changes only when an ADD completes
    p_e_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(t[5] && d[1]) |=> $stable(e));
endmodule

bind acc_seq_core acc_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sc    (sc_q),
    .t     (t),
    .d     (d),
    .pc    (pc_q),
    .ac    (ac_q),
    .e     (e_q)
);

// File: tb/acc_seq_core_tb_top.sv
`timescale 1ns/1ps
// Program-driven bench: preloads code and data, then walks a table of
// instruction rows, checking AC, PC and E after each instruction's last edge.
module acc_seq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] acc_out;
    logic [11:0] pc_out;
    logic        e_out;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    acc_seq_core dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .acc_out (acc_out),
        .pc_out  (pc_out),
        .e_out   (e_out)
    );

    typedef struct packed {
        logic [11:0] at;
        logic [15:0] instr;
        logic [3:0]  cyc;
        logic [15:0] ac;
        logic [11:0] pc;
        logic        e;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 14;
    localparam row_t ROWS [NROWS] = '{
        '{12'h000, 16'h2100, 4'd6, 16'h1234, 12'h001, 1'b0, 4'd3},  // R3 LDA
        '{12'h001, 16'h0101, 4'd6, 16'h1030, 12'h002, 1'b0, 4'd4},  // R4 AND
        '{12'h002, 16'h1102, 4'd6, 16'h102F, 12'h003, 1'b1, 4'd5},  // R5 carry
        '{12'h003, 16'h9104, 4'd6, 16'h112E, 12'h004, 1'b0, 4'd6},  // R6 indirect ADD
        '{12'h004, 16'h2103, 4'd6, 16'h0001, 12'h005, 1'b0, 4'd3},  // R3 LDA
        '{12'h005, 16'h1102, 4'd6, 16'h0000, 12'h006, 1'b1, 4'd5},  // R5 zero+carry
        '{12'h006, 16'h3000, 4'd5, 16'h0000, 12'h007, 1'b1, 4'd8},  // R8 code 3
        '{12'h007, 16'h7800, 4'd4, 16'h0000, 12'h008, 1'b1, 4'd9},  // R9 code 7
        '{12'h008, 16'hF000, 4'd4, 16'h0000, 12'h009, 1'b1, 4'd9},  // R9 code 7, I=1
        '{12'h009, 16'hC105, 4'd5, 16'h0000, 12'h00A, 1'b1, 4'd8},  // R8 code 4, I=1
        '{12'h00A, 16'h5200, 4'd6, 16'h0000, 12'h201, 1'b1, 4'd7},  // R7 BSA
        '{12'h201, 16'h2200, 4'd6, 16'h000B, 12'h202, 1'b1, 4'd7},  // R7 saved PC
        '{12'h202, 16'hD104, 4'd6, 16'h000B, 12'h106, 1'b1, 4'd7},  // R7 indirect BSA
        '{12'h106, 16'h2105, 4'd6, 16'h0203, 12'h107, 1'b1, 4'd7}   // R7 saved PC
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic [11:0] a, input logic [15:0] v);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic check_regs(input int req, input logic [15:0] ac,
                              input logic [11:0] pc, input logic e);
        chk(req, "AC", {16'h0, acc_out}, {16'h0, ac});
        chk(req, "PC", {20'h0, pc_out}, {20'h0, pc});
        chk(req, "E",  {31'h0, e_out}, {31'h0, e});
    endtask

    initial begin : watchdog
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        // R10: all preloads happen under reset
        repeat (3) @(posedge clk);
        for (int k = 0; k < NROWS; k++) preload(ROWS[k].at, ROWS[k].instr);
        preload(12'h100, 16'h1234);
        preload(12'h101, 16'hF0F0);
        preload(12'h102, 16'hFFFF);
        preload(12'h103, 16'h0001);
        preload(12'h104, 16'h0105);
        preload(12'h105, 16'h00FF);
        preload(12'h200, 16'hDEAD);
        @(negedge clk);
        check_regs(1, 16'h0000, 12'h000, 1'b0);  // R1 reset state

        rst_n = 1'b1;
        for (int k = 0; k < NROWS; k++) begin
            repeat (ROWS[k].cyc) @(posedge clk);
            @(negedge clk);
            check_regs(int'(ROWS[k].req), ROWS[k].ac, ROWS[k].pc, ROWS[k].e);
        end
        // R11: back-to-back run lands exactly on the final address
        chk(11, "PC end", {20'h0, pc_out}, 32'h107);
        // R2: sequential fetch covered by rows 0..9 advancing PC by one

        // R1: reset in the middle of an instruction
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_regs(1, 16'h0000, 12'h000, 1'b0);
        // R10: new operand through the preload port, then restart at T0
        preload(12'h100, 16'h8001);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(10, "AC preload", {16'h0, acc_out}, 32'h8001);
        chk(1, "PC restart", {20'h0, pc_out}, 32'h001);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule